// File: doc/BRIEF.md
# ADC Power Mode Sequencer

This block sits between a host and a sampling ADC that has two low-power control lines. One line selects a light sleep, here called nap. The other selects a deep sleep, here called standby. The host requests a power state and says whether the converter runs from its internal or from an external reference. The block then drives the two sleep lines. When the converter is brought back to normal operation, the block holds a ready flag low for a fixed wake-up time. That time depends on which sleep state was left and on which reference is in use.

Convert-start requests go to the converter only while ready is high. A conversion started before the wake-up time has elapsed would return corrupt data, so any request that arrives while ready is low is dropped and counted. The light sleep cannot be combined with the internal reference. A request for that combination is refused: an error flag is raised and the power state does not change. Every wake-up time is a parameter given in clock cycles.

Top module: `adc_pwr_seq`

## Requirements
- R1: After reset, both sleep outputs are low, ready is high, the error flag is low and the drop count is zero.
- R2: The request code is 0 for normal, 1 for nap and 2 for standby. From the cycle after the clock edge that accepts a request, `napOut` is high exactly while in nap and `stbyOut` is high exactly while in standby. The two are never high together.
- R3: Ready goes low from the cycle after the edge that accepts any low-power request, and it stays low for as long as either sleep output is high.
- R4: After the edge that accepts a return to normal from nap, ready rises exactly NAP_WAKE clock edges later. The reference flag does not change this delay.
- R5: After the edge that accepts a return to normal from standby with `intRef` = 1, ready rises exactly STBY_INT_WAKE edges later.
- R6: After the edge that accepts a return to normal from standby with `intRef` = 0, ready rises exactly STBY_EXT_WAKE edges later. The reference flag is sampled on that same edge.
- R7: A nap request (code 1) made with `intRef` = 1 while not already in nap leaves the state unchanged, and `reqError` is high in the following cycle. In every other case `reqError` is low.
- R8: `convStart` equals `convReq` while ready is high and is 0 while ready is low.
- R9: On each edge where `convReq` is high and ready is low, `dropCount` increments. It holds at its maximum value, 2^DROP_W - 1.
- R10: Nap and standby may be entered directly from each other, subject to R7. A sleep request made during a wake-up countdown cancels the countdown. The next wake-up then uses the delay of the newer sleep state.
- R11: Request code 3 is ignored: state, outputs and any countdown in progress continue as if the current state had been requested.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqState | input | 2 | Requested power state: 0 normal, 1 nap, 2 standby, 3 ignored |
| intRef | input | 1 | 1 when the internal reference is in use |
| convReq | input | 1 | Convert-start request from the host |
| napOut | output | 1 | Nap control line to the converter |
| stbyOut | output | 1 | Standby control line to the converter |
| ready | output | 1 | Converter is awake and may start a conversion |
| convStart | output | 1 | Gated convert-start to the converter |
| reqError | output | 1 | Illegal nap-with-internal-reference request was refused |
| dropCount | output | DROP_W | Saturating count of dropped convert requests |

## Verification
The bench sweeps every pair of requested states and reference flags, from every reachable starting state. At each step it compares all outputs against an arithmetic model of the requirements. It also measures the wake-up latency for each of the three paths out of sleep. A design that loaded the wrong delay, or that took the reference flag from the wrong moment, would give ready one or more cycles early or late. An off-by-one countdown would let a convert start through into a converter that is not yet settled. The bench also covers a nap refused from normal and from standby, a sleep request issued in the middle of a countdown, code 3 held during a countdown, and the drop counter running into its ceiling. A wrong design would, respectively: change state or forget the error pulse; lose the new delay; stall or restart the count; and wrap the counter back to zero.

// File: rtl/adc_pwr_pkg.sv
package adc_pwr_pkg;

  typedef enum logic [1:0] {
    PWR_NORMAL = 2'd0,
    PWR_NAP    = 2'd1,
    PWR_STBY   = 2'd2,
    PWR_RSVD   = 2'd3
  } pwrState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic loadWake;      // start a wake-up countdown
    logic wakeFromStby;  // countdown leaves standby (else nap)
    logic clearWait;     // sleep entry: cancel any countdown
    logic countDrop;     // a convert request was refused
  } seqStrobe_t;

endpackage

// File: rtl/adc_pwr_ctrl.sv
module adc_pwr_ctrl
  import adc_pwr_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic [1:0] reqState,
  input  logic       intRef,
  input  logic       convReq,
  input  logic       waitZero,
  output seqStrobe_t strb,
  output logic       napOut,
  output logic       stbyOut,
  output logic       ready,
  output logic       convStart,
  output logic       reqError
);

  pwrState_e curState;
  pwrState_e reqCode;
  logic      napRefused;
  logic      acceptSleep;
  logic      acceptWake;

  assign reqCode = pwrState_e'(reqState);

  always_comb begin
    napRefused  = (reqCode == PWR_NAP) && intRef && (curState != PWR_NAP);
    acceptSleep = ((reqCode == PWR_NAP) || (reqCode == PWR_STBY)) &&
                  (reqCode != curState) && !napRefused;
    acceptWake  = (reqCode == PWR_NORMAL) && (curState != PWR_NORMAL);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      curState <= PWR_NORMAL;
      reqError <= 1'b0;
    end else begin
      reqError <= napRefused;
      if (acceptSleep || acceptWake) curState <= reqCode;
    end
  end

  assign napOut    = (curState == PWR_NAP);
  assign stbyOut   = (curState == PWR_STBY);
  assign ready     = (curState == PWR_NORMAL) && waitZero;
  assign convStart = convReq && ready;

  always_comb begin
    strb.loadWake     = acceptWake;
    strb.wakeFromStby = (curState == PWR_STBY);
    strb.clearWait    = acceptSleep;
    strb.countDrop    = convReq && !ready;
  end

  AST_SLEEP_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    !(napOut && stbyOut)); // R2
  AST_SLEEP_NOT_READY: assert property (@(posedge clk) disable iff (!rstN)
    (napOut || stbyOut) |-> !ready); // R3
  AST_REFUSE_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    reqError |-> (curState == $past(curState))); // R7
  AST_NAP_EXT_ONLY: assert property (@(posedge clk) disable iff (!rstN)
    $rose(napOut) |-> $past(!intRef)); // R7
  AST_START_AWAKE: assert property (@(posedge clk) disable iff (!rstN)
    convStart |-> (!napOut && !stbyOut)); // R8

endmodule

// File: rtl/adc_pwr_dp.sv
module adc_pwr_dp
  import adc_pwr_pkg::*;
#(
  parameter int unsigned NAP_WAKE      = 30,
  parameter int unsigned STBY_EXT_WAKE = 8000,
  parameter int unsigned STBY_INT_WAKE = 50000000,
  parameter int unsigned DROP_W        = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobe_t        strb,
  input  logic              intRef,
  output logic              waitZero,
  output logic [DROP_W-1:0] dropCount
);

  localparam int unsigned STBY_MAX = (STBY_EXT_WAKE > STBY_INT_WAKE) ?
                                     STBY_EXT_WAKE : STBY_INT_WAKE;
  localparam int unsigned WAKE_MAX = (NAP_WAKE > STBY_MAX) ? NAP_WAKE : STBY_MAX;
  localparam int unsigned WAIT_W   = $clog2(WAKE_MAX + 1);

  logic [WAIT_W-1:0] waitCnt;
  logic [WAIT_W-1:0] wakeDelay;

  always_comb begin
    if (!strb.wakeFromStby) wakeDelay = WAIT_W'(NAP_WAKE);
    else if (intRef)        wakeDelay = WAIT_W'(STBY_INT_WAKE);
    else                    wakeDelay = WAIT_W'(STBY_EXT_WAKE);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      waitCnt <= '0;
    end else if (strb.clearWait) begin
      waitCnt <= '0;
    end else if (strb.loadWake) begin
      waitCnt <= wakeDelay;
    end else if (waitCnt != '0) begin
      waitCnt <= waitCnt - WAIT_W'(1);
    end
  end

  assign waitZero = (waitCnt == '0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      dropCount <= '0;
    end else if (strb.countDrop && (dropCount != '1)) begin
      dropCount <= dropCount + DROP_W'(1);
    end
  end

  AST_WAKE_LOADED: assert property (@(posedge clk) disable iff (!rstN)
    (strb.loadWake && !strb.clearWait) |=> !waitZero); // R4
  AST_WAIT_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (!waitZero && !strb.loadWake && !strb.clearWait) |=>
      (waitCnt == $past(waitCnt) - WAIT_W'(1))); // R5
  AST_DROP_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (strb.countDrop && (dropCount != '1)) |=>
      (dropCount == $past(dropCount) + DROP_W'(1))); // R9
  AST_DROP_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !strb.countDrop |=> $stable(dropCount)); // R9

endmodule

// File: rtl/adc_pwr_seq.sv
module adc_pwr_seq
  import adc_pwr_pkg::*;
#(
  parameter int unsigned NAP_WAKE      = 30,
  parameter int unsigned STBY_EXT_WAKE = 8000,
  parameter int unsigned STBY_INT_WAKE = 50000000,
  parameter int unsigned DROP_W        = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [1:0]        reqState,
  input  logic              intRef,
  input  logic              convReq,
  output logic              napOut,
  output logic              stbyOut,
  output logic              ready,
  output logic              convStart,
  output logic              reqError,
  output logic [DROP_W-1:0] dropCount
);

  seqStrobe_t strb;
  logic       waitZero;

  adc_pwr_ctrl ctrl_i (
    .clk       (clk),
    .rstN      (rstN),
    .reqState  (reqState),
    .intRef    (intRef),
    .convReq   (convReq),
    .waitZero  (waitZero),
    .strb      (strb),
    .napOut    (napOut),
    .stbyOut   (stbyOut),
    .ready     (ready),
    .convStart (convStart),
    .reqError  (reqError)
  );

  adc_pwr_dp #(
    .NAP_WAKE      (NAP_WAKE),
    .STBY_EXT_WAKE (STBY_EXT_WAKE),
    .STBY_INT_WAKE (STBY_INT_WAKE),
    .DROP_W        (DROP_W)
  ) dp_i (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .intRef    (intRef),
    .waitZero  (waitZero),
    .dropCount (dropCount)
  );

endmodule

// File: tb/adc_pwr_seq_tb.sv
module adc_pwr_seq_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int NAP_W  = 3;
  localparam int EXT_W  = 5;
  localparam int INT_W  = 8;
  localparam int DW     = 4;
  localparam int DMAX   = (1 << DW) - 1;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [1:0]    reqState = 2'd0;
  logic          intRef = 1'b0;
  logic          convReq = 1'b0;
  logic          napOut, stbyOut, ready, convStart, reqError;
  logic [DW-1:0] dropCount;

  int checks = 0;
  int errors = 0;
  int mState = 0;
  int mCnt = 0;
  int mDrop = 0;
  int mErr = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  adc_pwr_seq #(
    .NAP_WAKE(NAP_W), .STBY_EXT_WAKE(EXT_W), .STBY_INT_WAKE(INT_W), .DROP_W(DW)
  ) dut_i (
    .clk(clk), .rstN(rstN), .reqState(reqState), .intRef(intRef),
    .convReq(convReq), .napOut(napOut), .stbyOut(stbyOut), .ready(ready),
    .convStart(convStart), .reqError(reqError), .dropCount(dropCount)
  );

  function automatic int mReady();
    return (mState == 0 && mCnt == 0) ? 1 : 0;
  endfunction

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  // one clock step against the model; called just after a falling edge
  task automatic step(int req, int rf, int cr);
    int nErr;
    reqState = req[1:0];
    intRef   = rf[0];
    convReq  = cr[0];
    #1;
    check("R8 convStart", int'(convStart), (cr != 0 && mReady() != 0) ? 1 : 0);
    @(posedge clk);
    nErr = (req == 1 && rf != 0 && mState != 1) ? 1 : 0;
    if (cr != 0 && mReady() == 0 && mDrop < DMAX) mDrop++;
    if (req == 3 || req == mState || nErr != 0) begin
      if (mCnt > 0) mCnt--;
    end else if (req == 0) begin
      mCnt   = (mState == 1) ? NAP_W : ((rf != 0) ? INT_W : EXT_W);
      mState = 0;
    end else begin
      mState = req;
      mCnt   = 0;
    end
    mErr = nErr;
    @(negedge clk);
    check("R2 napOut", int'(napOut), (mState == 1) ? 1 : 0);
    check("R2 stbyOut", int'(stbyOut), (mState == 2) ? 1 : 0);
    check("R3 R4 R5 R6 ready", int'(ready), mReady());
    check("R7 reqError", int'(reqError), mErr);
    check("R9 dropCount", int'(dropCount), mDrop);
  endtask

  // wake request, then count edges until ready
  task automatic measureWake(int rf, int expDelay, string tag);
    int n = 0;
    step(0, rf, 0);
    while (ready == 1'b0 && n < 100) begin
      step(0, rf, 0);
      n++;
    end
    check(tag, n, expDelay);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    summary();
  end

  initial begin : stim
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 napOut", int'(napOut), 0);
    check("R1 stbyOut", int'(stbyOut), 0);
    check("R1 ready", int'(ready), 1);
    check("R1 reqError", int'(reqError), 0);
    check("R1 dropCount", int'(dropCount), 0);

    // exact wake latencies
    step(1, 0, 0);
    check("R3 ready low in nap", int'(ready), 0);
    measureWake(1, NAP_W, "R4 nap wake delay");
    step(2, 1, 0);
    measureWake(1, INT_W, "R5 standby internal wake delay");
    step(2, 1, 0);
    measureWake(0, EXT_W, "R6 standby external wake delay");

    // refused nap from normal and from standby
    step(1, 1, 0);
    check("R7 nap refused stays normal", int'(napOut), 0);
    step(2, 0, 0);
    step(1, 1, 0);
    check("R7 nap refused stays standby", int'(stbyOut), 1);
    step(1, 0, 0);
    check("R10 standby to nap direct", int'(napOut), 1);
    step(2, 1, 0);
    check("R10 nap to standby direct", int'(stbyOut), 1);

    // sleep during countdown, then wake uses the newer delay
    step(0, 0, 1);
    step(0, 0, 1);
    step(1, 0, 1);
    measureWake(0, NAP_W, "R10 countdown cancelled by nap");

    // code 3 during countdown keeps counting
    step(2, 0, 0);
    step(0, 0, 0);
    for (int i = 0; i < EXT_W - 1; i++) step(3, 0, 1);
    check("R11 ignored code, still waiting", int'(ready), 0);
    step(3, 0, 1);
    check("R11 ignored code, countdown finished", int'(ready), 1);

    // near-exhaustive sweep: start state x ref x target x ref
    for (int s = 0; s < 4; s++)
      for (int r0 = 0; r0 < 2; r0++)
        for (int t = 0; t < 4; t++)
          for (int r1 = 0; r1 < 2; r1++) begin
            for (int k = 0; k < INT_W + 2; k++) step(0, 0, 0);
            step(s, r0, 1);
            step(t, r1, 0);
            for (int k = 0; k < INT_W + 2; k++) step(t, r1, k % 2);
          end

    // drop counter has saturated over the sweep
    step(2, 0, 1);
    step(2, 0, 1);
    check("R9 dropCount saturated", int'(dropCount), DMAX);

    summary();
  end

endmodule